// File: doc/BRIEF.md
# Idle-Locked Stream Descrambler

This block sits in the receive path of a 100 Mb/s twisted-pair style link, right after the clock recovery and NRZI decoder. It takes one scrambled line bit per accepted clock and returns the plain bit. The remote end scrambles with an 11-stage keystream generator, so the block has to find that generator's state from the line before it can descramble anything. A plain idle line carries all ones. While the line is idle, each received bit is therefore the inverted keystream bit. During acquisition the block shifts the inverted line bits into its own 11-bit register and counts how many arrivals in a row agree with the register's own prediction. A long enough agreeing run declares lock.

Once locked, the register runs freely from its own feedback, and every accepted line bit is XORed with the keystream. A supervising watchdog keeps lock alive only while the plain stream keeps showing idle. Each time a run of ones of the required length arrives, the watchdog is reloaded. If the countdown reaches its end first, lock is dropped, a one-cycle unlock event is raised, and acquisition starts again. A configuration input selects the longer of two timeout lengths. Both lengths are parameters in clock cycles.

Top module: `stream_descrambler`

## Requirements
- R1: After reset, `locked`, `unlockPulse` and `plainBit` are all 0.
- R2: While unlocked, `locked` rises at the clock edge that accepts the LOCK_RUN-th consecutive accepted bit whose inverse matches the predicted keystream bit. The keystream is s[n] = s[n-11] XOR s[n-9]. From a reset register, lock comes no earlier than LOCK_RUN and no later than LOCK_RUN+11 idle bits.
- R3: During acquisition, an accepted bit that is not scrambled idle restarts the agreeing run. No lock can follow within the next LOCK_RUN-1 idle bits.
- R4: While locked, each accepted bit updates `plainBit` one cycle later to the line bit XOR the keystream bit.
- R5: Cycles with `rxValid` low accept nothing. They do not advance the register or either run count, and `plainBit` holds its value.
- R6: With `holdExtend` low at the lock edge, `locked` stays high for exactly HOLD_SHORT cycles if no qualifying idle run arrives.
- R7: With `holdExtend` high at the lock edge or at a reload, the window is HOLD_LONG cycles.
- R8: A run of IDLE_NEED consecutive accepted plain ones reloads the hold timer. A run of IDLE_NEED-1 ones followed by a zero does not.
- R9: When the timer expires, `locked` falls and `unlockPulse` is high for exactly that one cycle. `unlockPulse` is never high otherwise.
- R10: After an unlock, acquisition restarts from an empty run. With idle on the line, lock returns after exactly LOCK_RUN accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Scrambled line bit |
| rxValid | input | 1 | rxBit is accepted this cycle |
| holdExtend | input | 1 | Selects the long hold window on load |
| plainBit | output | 1 | Descrambled bit, updated for each bit accepted in lock |
| locked | output | 1 | Descrambler is synchronized |
| unlockPulse | output | 1 | One-cycle event when lock is lost |

## Verification
The hardest point to reach from the ports is the boundary of the watchdog. The hold time has to be measured exactly, and a run one bit short of the reload length must be shown to leave the countdown untouched. The bench reaches it by locking on a clean idle run and then feeding a repeating pattern of IDLE_NEED-1 ones and a zero, counting locked cycles until the drop. The exact relock count after an unlock is used the same way: the keystream register is already aligned at that moment, so the count must come out at exactly LOCK_RUN.

// File: rtl/descr_pkg.sv
package descr_pkg;
  // Strobes from the lock controller to the keystream datapath
  typedef struct packed {
    logic advance;     // accept the current line bit
    logic followLine;  // load inverted line bit (acquisition) instead of feedback
    logic emitOut;     // capture a descrambled bit on the output
  } dscStrobe_t;
endpackage

// File: rtl/descr_datapath.sv
module descr_datapath
  import descr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  dscStrobe_t strobe,
  output logic       plainIsOne,
  output logic       plainBit
);
  localparam int STAGES = 11;
  localparam int TAP_A  = 10;  // s[n-11]
  localparam int TAP_B  = 8;   // s[n-9]

  logic [STAGES-1:0] keyReg;
  logic              keyBit;
  logic              nextIn;

  assign keyBit     = keyReg[TAP_A] ^ keyReg[TAP_B];
  assign plainIsOne = rxBit ^ keyBit;
  assign nextIn     = strobe.followLine ? ~rxBit : keyBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg   <= '0;
      plainBit <= 1'b0;
    end else begin
      if (strobe.advance) keyReg <= {keyReg[STAGES-2:0], nextIn};
      if (strobe.emitOut) plainBit <= rxBit ^ keyBit;
    end
  end

  assert_hold_plain_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(plainBit));
endmodule

// File: rtl/descr_control.sv
module descr_control
  import descr_pkg::*;
#(
  parameter int LOCK_RUN   = 40,
  parameter int IDLE_NEED  = 60,
  parameter int HOLD_SHORT = 90250,
  parameter int HOLD_LONG  = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       holdExtend,
  input  logic       plainIsOne,
  output dscStrobe_t strobe,
  output logic       locked,
  output logic       unlockPulse
);
  localparam int HOLD_MAX = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
  localparam int TW = $clog2(HOLD_MAX + 1);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int IW = $clog2(IDLE_NEED + 1);

  logic [RW-1:0] runCnt;
  logic [IW-1:0] idleCnt;
  logic [TW-1:0] holdTimer;
  logic [TW-1:0] reloadVal;
  logic          idleHit;
  logic          runDone;

  assign strobe.advance    = rxValid;
  assign strobe.followLine = !locked;
  assign strobe.emitOut    = rxValid && locked;

  assign reloadVal = holdExtend ? TW'(HOLD_LONG - 1) : TW'(HOLD_SHORT - 1);
  assign idleHit   = rxValid && plainIsOne && (idleCnt == IW'(IDLE_NEED - 1));
  assign runDone   = runCnt == RW'(LOCK_RUN - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked      <= 1'b0;
      unlockPulse <= 1'b0;
      runCnt      <= '0;
      idleCnt     <= '0;
      holdTimer   <= '0;
    end else begin
      unlockPulse <= 1'b0;
      if (!locked) begin
        if (rxValid) begin
          if (!plainIsOne) begin
            runCnt <= '0;
          end else if (runDone) begin
            locked    <= 1'b1;
            runCnt    <= '0;
            idleCnt   <= '0;
            holdTimer <= reloadVal;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end
      end else begin
        if (rxValid) begin
          if (!plainIsOne)  idleCnt <= '0;
          else if (idleHit) idleCnt <= '0;
          else              idleCnt <= idleCnt + 1'b1;
        end
        if (idleHit) begin
          holdTimer <= reloadVal;
        end else if (holdTimer == '0) begin
          locked      <= 1'b0;
          unlockPulse <= 1'b1;
          runCnt      <= '0;
        end else begin
          holdTimer <= holdTimer - 1'b1;
        end
      end
    end
  end

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> runCnt < RW'(LOCK_RUN));
  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdTimer < TW'(HOLD_MAX));
  assert_lock_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(rxValid));
  assert_fall_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> unlockPulse);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    unlockPulse |=> !unlockPulse);
  assert_pulse_unlocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    unlockPulse |-> !locked);
endmodule

// File: rtl/stream_descrambler.sv
module stream_descrambler
  import descr_pkg::*;
#(
  parameter int LOCK_RUN   = 40,
  parameter int IDLE_NEED  = 60,
  parameter int HOLD_SHORT = 90250,
  parameter int HOLD_LONG  = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxBit,
  input  logic rxValid,
  input  logic holdExtend,
  output logic plainBit,
  output logic locked,
  output logic unlockPulse
);
  dscStrobe_t strobe;
  logic       plainIsOne;

  descr_control #(
    .LOCK_RUN(LOCK_RUN), .IDLE_NEED(IDLE_NEED),
    .HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .holdExtend(holdExtend),
    .plainIsOne(plainIsOne), .strobe(strobe), .locked(locked),
    .unlockPulse(unlockPulse)
  );

  descr_datapath u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strobe(strobe),
    .plainIsOne(plainIsOne), .plainBit(plainBit)
  );
endmodule

// File: tb/tb_stream_descrambler.sv
`timescale 1ns/1ps
module tb_stream_descrambler;
  localparam int LOCK_RUN   = 40;
  localparam int IDLE_NEED  = 60;
  localparam int HOLD_SHORT = 400;
  localparam int HOLD_LONG  = 900;

  logic clk = 1'b0;
  logic rstN, rxBit, rxValid, holdExtend;
  logic plainBit, locked, unlockPulse;

  int checks = 0;
  int fails  = 0;
  logic [10:0] bsr;  // bench scrambler, bsr[0] newest keystream bit

  always #10 clk = ~clk;  // 50 MHz

  stream_descrambler #(
    .LOCK_RUN(LOCK_RUN), .IDLE_NEED(IDLE_NEED),
    .HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)
  ) dut (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxValid(rxValid),
    .holdExtend(holdExtend), .plainBit(plainBit), .locked(locked),
    .unlockPulse(unlockPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scramble one plain bit, drive it, and advance to the next sample point
  task automatic step(input logic plain, input logic v);
    logic k;
    k = bsr[10] ^ bsr[8];
    rxBit   = plain ^ k;
    rxValid = v;
    if (v) bsr = {bsr[9:0], k};
    @(negedge clk);
  endtask

  // Feed idle until lock; n counts accepted bits starting at startCount
  task automatic acquire(input int startCount, input bit randValid, output int n);
    int guard = 0;
    n = startCount;
    while (!locked && guard < 400) begin
      logic v;
      v = randValid ? (($urandom % 4) != 0) : 1'b1;
      step(1'b1, v);
      if (v) n++;
      guard++;
    end
  endtask

  // From a lock sample, feed runs of IDLE_NEED-1 ones and a zero; count locked cycles
  task automatic measureHold(output int c);
    int p = 0;
    c = 1;
    while (locked && c < 3000) begin
      step((p % IDLE_NEED) != IDLE_NEED - 1, 1'b1);
      p++;
      if (locked) c++;
    end
    check(unlockPulse == 1'b1, "R9 pulse at drop", unlockPulse, 1);
    step(1'b1, 1'b1);
    check(unlockPulse == 1'b0, "R9 pulse one cycle", unlockPulse, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    int n, c, errs, stab;
    void'($urandom(32'd4242));
    bsr = 11'($urandom) | 11'd1;
    rstN = 1'b0; rxBit = 1'b0; rxValid = 1'b0; holdExtend = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(locked == 1'b0, "R1 locked", locked, 0);
    check(unlockPulse == 1'b0, "R1 pulse", unlockPulse, 0);
    check(plainBit == 1'b0, "R1 plain", plainBit, 0);
    rstN = 1'b1;

    // R2 initial acquisition from an empty register
    acquire(0, 1'b0, n);
    check(n >= LOCK_RUN && n <= LOCK_RUN + 11, "R2 first lock window", n, LOCK_RUN);

    // R4/R5/R8 random data with idle keep-alive runs, gaps in rxValid
    for (int seg = 0; seg < 6; seg++) begin
      int acc = 0;
      errs = 0; stab = 0;
      while (acc < 100) begin
        logic v, pl, prev;
        v = ($urandom % 4) != 0;
        pl = 1'($urandom);
        prev = plainBit;
        step(pl, v);
        if (v) begin acc++; if (plainBit != pl) errs++; end
        else if (plainBit != prev) stab++;
      end
      check(errs == 0, "R4 descrambled data", errs, 0);
      check(stab == 0, "R5 plainBit holds without valid", stab, 0);
      for (int i = 0; i < 70; i++) step(1'b1, 1'b1);
      check(locked == 1'b1, "R8 idle runs keep lock", locked, 1);
    end

    // Drop lock with short idle runs
    c = 0;
    while (locked && c < 2000) begin step((c % IDLE_NEED) != IDLE_NEED - 1, 1'b1); c++; end
    check(!locked && unlockPulse, "R9 unlock event", unlockPulse, 1);

    // R10 relock after unlock, with random valid gaps (R5)
    acquire(0, 1'b1, n);
    check(n == LOCK_RUN, "R10 R5 relock count", n, LOCK_RUN);

    // R6 R8: one-short idle runs do not reload, window exact
    measureHold(c);
    check(c == HOLD_SHORT, "R6 R8 short hold length", c, HOLD_SHORT);

    // R7 extended window
    holdExtend = 1'b1;
    acquire(1, 1'b0, n);
    check(n == LOCK_RUN, "R10 relock count", n, LOCK_RUN);
    measureHold(c);
    check(c == HOLD_LONG, "R7 long hold length", c, HOLD_LONG);
    holdExtend = 1'b0;

    // R3 a non-idle bit restarts the run
    for (int i = 0; i < 29; i++) step(1'b1, 1'b1);
    check(locked == 1'b0, "R3 no lock on short run", locked, 0);
    step(1'b0, 1'b1);
    for (int i = 0; i < LOCK_RUN - 1; i++) step(1'b1, 1'b1);
    check(locked == 1'b0, "R3 run restarted", locked, 0);
    acquire(LOCK_RUN - 1, 1'b0, n);
    check(locked && n <= LOCK_RUN + 11, "R3 lock after restart", n, LOCK_RUN);

    finishRun();
  end
endmodule